// File: doc/BRIEF.md
# Frequency Offset Capture Controller

This block keeps a 16-bit control word and a signed frequency-offset register that it fills from an externally measured offset. A host writes the control word through a parallel write port, which stands in for a serial command link. The upper byte of every write is a command code, and the block only accepts a write whose code matches its own. The lower byte chooses a capture mode, a manual strobe, an output enable and an adjustment enable. Two of its fields, range select and fine select, are only stored here for the analog side to use.

Each cycle, the selected mode decides whether the held offset takes the new measurement, keeps its value, or is cleared:

- In manual mode it captures only on a strobe.
- In single-shot mode it captures once after reset.
- In gated mode it follows the measurement while the valid-data indicator is high and is cleared while that indicator is low.
- In tracking mode it follows the measurement every cycle.

While a status read is in progress the held value is frozen. A strobe that arrives during that time waits until the read ends. The held offset goes to the status output, and is forced to zero there unless output is enabled.

Top module: `freq_offset_ctrl`

## Requirements
- R1: After reset, `ctrl_word` reads 0xC4F7 (tracking mode, strobe clear, output and adjustment enabled), and `stat_ofs` reads zero.
- R2: A write is accepted only when `wr_data[15:8]` equals 0xC4. An accepted write loads all 16 bits into `ctrl_word` on the next edge. A write with any other code leaves `ctrl_word` and the held offset unchanged.
- R3: The control fields are mode `[7:6]`, range `[5:4]`, strobe `[3]`, fine select `[2]`, output enable `[1]` and adjustment enable `[0]`. The strobe bit reads 1 for exactly one cycle after an accepted write that sets it, then clears itself. Each such write causes exactly one capture.
- R4: In mode 00 (manual), the held offset changes only through a pending strobe. That capture happens on the first edge after the write at which capture is allowed.
- R5: In mode 01 (single-shot), the held offset is captured once after reset, on the first edge at which capture is allowed, and is never updated again unless a strobe is written.
- R6: In mode 10 (gated), the held offset is cleared to zero on an edge where `data_ok` is low, and takes the measurement on an edge where `data_ok` is high.
- R7: In mode 11 (tracking), the held offset takes `meas_ofs` on every allowed edge, whatever the level of `data_ok`.
- R8: While `stat_rd` is high, the held offset does not change. A strobe written during that time is kept pending and is applied on the first allowed edge after `stat_rd` falls.
- R9: `stat_ofs` shows the held offset (sign-extended to `STAT_W`) when output enable is 1, and zero when it is 0.
- R10: While adjustment enable is 0, the held offset keeps its value in every mode, and a pending strobe stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write request |
| wr_data | input | 16 | Command code `[15:8]` and control fields `[7:0]` |
| meas_ofs | input | OFS_W | Measured signed offset |
| data_ok | input | 1 | Valid-data indicator, high when reception is good |
| stat_rd | input | 1 | Status read in progress |
| stat_ofs | output | STAT_W | Gated held offset for the status word |
| ctrl_word | output | 16 | Current control word |

## Verification
The bench targets the following corner cases:

- **Wrong command code.** A write with a near-miss code must not alter the control word. A design that accepted it would switch mode or fire a stray strobe.
- **Strobe pulse length.** A strobe that stays set for more than one cycle would show up as repeated captures in manual mode.
- **Strobe during a status read.** A strobe written while a read is in progress, or while adjustment is disabled, must be deferred rather than lost. A design that dropped it would never capture. A design that applied it at once would change the value being reported.
- **Single-shot mode.** A design that kept following the measurement would show drifting offsets after the first capture.
- **Gated versus tracking.** The bench drops `data_ok` in both modes. This catches a design that clears in the wrong mode or ignores the clear.

// File: rtl/fo_pkg.sv
package fo_pkg;

   typedef enum logic [1:0] {
      FO_MANUAL = 2'b00,
      FO_ONCE   = 2'b01,
      FO_GATED  = 2'b10,
      FO_TRACK  = 2'b11
   } fo_mode_e;

   typedef struct packed {
      logic [7:0] cmd;
      fo_mode_e   mode;
      logic [1:0] rng;
      logic       strobe;
      logic       fine;
      logic       out_en;
      logic       adj_en;
   } fo_ctrl_t;

   localparam int unsigned FO_CTRL_W = $bits(fo_ctrl_t);

endpackage

// File: rtl/fo_cmd_reg.sv
module fo_cmd_reg
   import fo_pkg::*;
#(
   parameter logic [7:0]  CMD_CODE = 8'hC4,
   parameter logic [15:0] CTRL_RST = 16'hC4F7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [15:0]     wr_data,
   output fo_ctrl_t        ctrl_q,
   output logic            strobe_set
);

   logic accept;

   // The written word must carry the matching command code in its upper byte.
   assign accept     = wr_en && (wr_data[15:8] == CMD_CODE);
   assign strobe_set = accept && wr_data[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= fo_ctrl_t'(CTRL_RST);
      end else if (accept) begin
         ctrl_q <= fo_ctrl_t'(wr_data);
      end else begin
         // The strobe bit is a one-cycle pulse.
         ctrl_q.strobe <= 1'b0;
      end
   end

endmodule

// File: rtl/fo_capture.sv
module fo_capture
   import fo_pkg::*;
#(
   parameter int unsigned OFS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fo_mode_e         mode,
   input  logic             adj_en,
   input  logic             strobe_set,
   input  logic             stat_rd,
   input  logic             data_ok,
   input  logic [OFS_W-1:0] meas,
   output logic [OFS_W-1:0] held_q
);

   logic pend_q;
   logic once_q;
   logic allow;
   logic take;
   logic clr;

   // Capture is allowed only when adjustment is enabled and no status read is running.
   assign allow = adj_en && !stat_rd;

   always_comb begin
      take = 1'b0;
      clr  = 1'b0;
      unique case (mode)
         FO_MANUAL: take = pend_q;
         FO_ONCE:   take = pend_q || !once_q;
         FO_GATED: begin
            clr  = !data_ok;
            take = data_ok;
         end
         FO_TRACK:  take = 1'b1;
         default:   take = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         pend_q <= 1'b0;
         once_q <= 1'b0;
      end else begin
         if (allow && clr) begin
            held_q <= '0;
         end else if (allow && take) begin
            held_q <= meas;
         end

         if (allow && (mode == FO_ONCE)) begin
            once_q <= 1'b1;
         end

         // A new strobe wins over consuming an older one.
         if (strobe_set) begin
            pend_q <= 1'b1;
         end else if (allow) begin
            pend_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/fo_status_out.sv
module fo_status_out #(
   parameter int unsigned OFS_W  = 8,
   parameter int unsigned STAT_W = 8
) (
   input  logic              out_en,
   input  logic [OFS_W-1:0]  held,
   output logic [STAT_W-1:0] stat
);

   logic [STAT_W-1:0] ext;

   generate
      if (STAT_W < OFS_W) begin : g_bad
         $error("fo_status_out: STAT_W must not be below OFS_W");
      end else if (STAT_W == OFS_W) begin : g_same
         assign ext = held;
      end else begin : g_sext
         assign ext = {{(STAT_W-OFS_W){held[OFS_W-1]}}, held};
      end
   endgenerate

   assign stat = out_en ? ext : '0;

endmodule

// File: rtl/freq_offset_ctrl.sv
module freq_offset_ctrl
   import fo_pkg::*;
#(
   parameter int unsigned OFS_W    = 8,
   parameter int unsigned STAT_W   = 8,
   parameter logic [7:0]  CMD_CODE = 8'hC4,
   parameter logic [15:0] CTRL_RST = 16'hC4F7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_data,
   input  logic [OFS_W-1:0]  meas_ofs,
   input  logic              data_ok,
   input  logic              stat_rd,
   output logic [STAT_W-1:0] stat_ofs,
   output logic [15:0]       ctrl_word
);

   generate
      if (OFS_W < 2) begin : g_w_chk
         $error("freq_offset_ctrl: OFS_W must be at least 2");
      end
      if (FO_CTRL_W != 16) begin : g_c_chk
         $error("freq_offset_ctrl: control struct must be 16 bits");
      end
   endgenerate

   fo_ctrl_t         ctrl_q;
   logic             strobe_set;
   logic [OFS_W-1:0] held_q;

   fo_cmd_reg #(
      .CMD_CODE (CMD_CODE),
      .CTRL_RST (CTRL_RST)
   ) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .ctrl_q     (ctrl_q),
      .strobe_set (strobe_set)
   );

   fo_capture #(
      .OFS_W (OFS_W)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (ctrl_q.mode),
      .adj_en     (ctrl_q.adj_en),
      .strobe_set (strobe_set),
      .stat_rd    (stat_rd),
      .data_ok    (data_ok),
      .meas       (meas_ofs),
      .held_q     (held_q)
   );

   fo_status_out #(
      .OFS_W  (OFS_W),
      .STAT_W (STAT_W)
   ) u_out (
      .out_en (ctrl_q.out_en),
      .held   (held_q),
      .stat   (stat_ofs)
   );

   assign ctrl_word = ctrl_q;

endmodule

// File: rtl/fo_ctrl_chk.sv
module fo_ctrl_chk #(
   parameter int unsigned OFS_W    = 8,
   parameter int unsigned STAT_W   = 8,
   parameter logic [7:0]  CMD_CODE = 8'hC4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [15:0]       wr_data,
   input logic              data_ok,
   input logic              stat_rd,
   input logic [STAT_W-1:0] stat_ofs,
   input logic [15:0]       ctrl_word,
   input logic [OFS_W-1:0]  held
);

   logic good_wr;
   assign good_wr = wr_en && (wr_data[15:8] == CMD_CODE);

   // R2
   bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !good_wr && !ctrl_word[3]) |=> $stable(ctrl_word));

   // R3
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[3] && !(good_wr && wr_data[3])) |=> !ctrl_word[3]);

   // R6
   gated_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[7:6] == 2'b10 && ctrl_word[0] && !stat_rd && !data_ok) |=> (held == '0));

   // R8
   read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> $stable(held));

   // R9
   out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_word[1] |-> (stat_ofs == '0));

   // R10
   adj_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_word[0] |=> $stable(held));

endmodule

bind freq_offset_ctrl fo_ctrl_chk #(
   .OFS_W    (OFS_W),
   .STAT_W   (STAT_W),
   .CMD_CODE (CMD_CODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .data_ok   (data_ok),
   .stat_rd   (stat_rd),
   .stat_ofs  (stat_ofs),
   .ctrl_word (ctrl_word),
   .held      (held_q)
);

// File: tb/tb_freq_offset_ctrl.sv
module tb_freq_offset_ctrl;

   localparam int unsigned OFS_W   = 8;
   localparam int unsigned STAT_W  = 8;
   localparam time         CLK_PER = 10ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [15:0]       wr_data = '0;
   logic [OFS_W-1:0]  meas_ofs = '0;
   logic              data_ok = 1'b0;
   logic              stat_rd = 1'b0;
   logic [STAT_W-1:0] stat_ofs;
   logic [15:0]       ctrl_word;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string tag = "R1";

   // reference state
   logic [15:0]      m_ctrl;
   logic [OFS_W-1:0] m_held;
   bit               m_pend;
   bit               m_once;

   always #(CLK_PER/2) clk = ~clk;

   freq_offset_ctrl #(.OFS_W(OFS_W), .STAT_W(STAT_W)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .meas_ofs(meas_ofs), .data_ok(data_ok), .stat_rd(stat_rd),
      .stat_ofs(stat_ofs), .ctrl_word(ctrl_word));

   function automatic logic [STAT_W-1:0] exp_stat(logic [15:0] c, logic [OFS_W-1:0] h);
      return c[1] ? STAT_W'(h) : '0;
   endfunction

   task automatic check(string t, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit acc, allow, take, clr;
      logic [1:0] md;
      logic [15:0] nc;
      logic [OFS_W-1:0] nh;
      bit np, no;
      acc   = wr_en && wr_data[15:8] == 8'hC4;
      allow = m_ctrl[0] && !stat_rd;
      md    = m_ctrl[7:6];
      take  = 0; clr = 0;
      case (md)
         2'b00: take = m_pend;
         2'b01: take = m_pend || !m_once;
         2'b10: begin clr = !data_ok; take = data_ok; end
         default: take = 1;
      endcase
      nh = m_held;
      if (allow && clr) nh = '0;
      else if (allow && take) nh = meas_ofs;
      no = m_once || (allow && md == 2'b01);
      np = acc && wr_data[3] ? 1'b1 : (allow ? 1'b0 : m_pend);
      nc = acc ? wr_data : (m_ctrl & 16'hFFF7);
      m_ctrl = nc; m_held = nh; m_pend = np; m_once = no;
   endtask

   // one clock: model and DUT advance together, outputs compared at the falling edge
   task automatic step();
      model_step();
      @(posedge clk);
      @(negedge clk);
      check({tag, " ctrl_word"}, 32'(ctrl_word), 32'(m_ctrl));
      check({tag, " stat_ofs"}, 32'(stat_ofs), 32'(exp_stat(m_ctrl, m_held)));
   endtask

   task automatic idle();
      wr_en = 0; wr_data = '0;
   endtask

   task automatic wr(logic [15:0] d);
      wr_en = 1; wr_data = d; step(); idle();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      m_ctrl = 16'hC4F7; m_held = '0; m_pend = 0; m_once = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset ctrl", 32'(ctrl_word), 32'h0000C4F7);
      check("R1 reset stat", 32'(stat_ofs), 32'h0);
      rst_n = 1;
      @(negedge clk);
      m_held = '0;

      // R7 tracking regardless of data_ok
      tag = "R7";
      for (int i = 0; i < 6; i++) begin
         meas_ofs = OFS_W'(8'h10 + i); data_ok = i[0]; step();
      end
      check("R7 tracks last", 32'(stat_ofs), 32'h15);

      // R2 wrong codes ignored
      tag = "R2";
      wr(16'hC54B); wr(16'h444B); wr(16'hC40B & 16'h00FF);
      check("R2 ctrl kept", 32'(ctrl_word), 32'h0000C4F7);

      // R4 manual mode: only a strobe captures; R3 pulse and one capture per write
      tag = "R4";
      meas_ofs = 8'h33;
      wr(16'hC403);
      meas_ofs = 8'h44; step(); step();
      check("R4 no capture without strobe", 32'(stat_ofs), 32'h33);
      tag = "R3";
      meas_ofs = 8'h55;
      wr(16'hC40B);
      check("R3 strobe bit high once", 32'(ctrl_word[3]), 32'h1);
      meas_ofs = 8'h66; step();
      check("R3 strobe self clear", 32'(ctrl_word[3]), 32'h0);
      check("R3 one capture", 32'(stat_ofs), 32'h66);
      meas_ofs = 8'h77; step();
      check("R3 no second capture", 32'(stat_ofs), 32'h66);

      // R8 strobe during status read deferred
      tag = "R8";
      stat_rd = 1; meas_ofs = 8'h81;
      wr(16'hC40B);
      step(); step();
      check("R8 frozen during read", 32'(stat_ofs), 32'h66);
      stat_rd = 0; meas_ofs = 8'h92; step();
      check("R8 deferred strobe applied", 32'(stat_ofs), 32'h92);

      // R10 adjustment disabled keeps pending strobe
      tag = "R10";
      wr(16'hC40A);
      meas_ofs = 8'hA1; step(); step();
      check("R10 held kept", 32'(stat_ofs), 32'h92);
      wr(16'hC403);
      meas_ofs = 8'hA5; step();
      check("R10 pending applied after enable", 32'(stat_ofs), 32'hA5);

      // R9 output gating
      tag = "R9";
      wr(16'hC4C1); step();
      check("R9 gated to zero", 32'(stat_ofs), 32'h0);
      wr(16'hC4C3);

      // R6 gated mode
      tag = "R6";
      data_ok = 1; meas_ofs = 8'hC8;
      wr(16'hC483); step();
      check("R6 follows when ok", 32'(stat_ofs), 32'hC8);
      data_ok = 0; step();
      check("R6 cleared when low", 32'(stat_ofs), 32'h0);
      data_ok = 1; meas_ofs = 8'hF0; step();
      check("R6 resumes", 32'(stat_ofs), 32'hF0);

      // R5 single-shot after reset
      tag = "R5";
      rst_n = 0; @(negedge clk);
      m_ctrl = 16'hC4F7; m_held = '0; m_pend = 0; m_once = 0;
      rst_n = 1;
      wr(16'hC453);
      meas_ofs = 8'h5A; step();
      check("R5 first capture", 32'(stat_ofs), 32'h5A);
      for (int i = 0; i < 4; i++) begin meas_ofs = OFS_W'(i * 3 + 1); step(); end
      check("R5 no update after once", 32'(stat_ofs), 32'h5A);

      // mixed random phase, all rules
      tag = "R2/R3/R4/R5/R6/R7/R8/R9/R10 random";
      for (int i = 0; i < 3000; i++) begin
         wr_en    = ($urandom % 8) == 0;
         wr_data  = {(($urandom % 5) == 0) ? 8'($urandom) : 8'hC4, 8'($urandom)};
         meas_ofs = OFS_W'($urandom);
         data_ok  = ($urandom % 4) != 0;
         stat_rd  = ($urandom % 5) == 0;
         step();
      end
      idle(); stat_rd = 0;

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule